// File: doc/BRIEF.md
# Prescaled Reload Event Counter

This block turns a slow, periodic clock-enable into a count of longer periods. A down-counter steps once per tick. After it has spent one tick at zero, it reloads from a software-set reload value, and an event counter advances by one on that same tick. The event counter therefore advances once every (reload + 1) ticks. A reload value of zero makes the down-counter stay at zero, so the event counter advances on every tick.

Software can write all three values (reload, down-counter and event counter) through separate write strobes that share one data bus. A write replaces the value immediately, and all three values are visible on output ports at all times. The tick is a single-cycle enable that is synchronous to the block clock. Its nominal rate is set by a parameter, 20 MHz by default against a 250 MHz clock. Bus decoding and tick generation are done outside the block.

Top module: `prescaled_event_counter`

## Requirements
- R1: While reset is active and in the first cycle after it, the reload value, the down-counter and the event counter all read zero.
- R2: On a tick where the down-counter is non-zero and is not being written, it decreases by one in the next cycle, and the event counter keeps its value.
- R3: On a tick where the down-counter is already zero, the down-counter takes the reload value and the event counter increases by one, both in the next cycle.
- R4: With a reload value of zero, the down-counter stays at zero and the event counter increases by one on every tick.
- R5: In a cycle with no tick and no write strobe, none of the three values changes.
- R6: A write strobe replaces the chosen register with the data bus value, and the new value is visible in the next cycle.
- R7: When a write and a tick arrive in the same cycle, the write wins for the register being written. The other register still follows its tick rule, judged on the down-counter value before the write.
- R8: Writing the reload value does not change a down-count already in progress. The new value is used only at the next reload. A reload in the same cycle as a reload write uses the old value.
- R9: The event counter is 32 bits wide and wraps from 0xFFFFFFFF to 0.
- R10: Starting with reload 5 and down-counter 7, fourteen ticks give the down-counter values 6,5,4,3,2,1,0,5,4,3,2,1,0,5, and the event counter increases on the 8th and the 14th tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Single-cycle prescale clock-enable |
| wrPrescale | input | 1 | Write strobe for the reload value |
| wrDown | input | 1 | Write strobe for the down-counter |
| wrCount | input | 1 | Write strobe for the event counter |
| wrData | input | 32 | Write data shared by the strobes |
| prescaleVal | output | 32 | Current reload value |
| downVal | output | 32 | Current down-counter value |
| countVal | output | 32 | Current event counter value |

## Verification
The assertions assume that `tick` is a single-cycle pulse with at least CLK_HZ/TICK_HZ clock cycles between pulses (12 at the defaults). A guard in the control checks that spacing. The assertions also assume that write strobes may coincide with a tick, with each strobe naming one register. The bench keeps every tick apart from the next by an idle gap longer than that minimum. It places writes either in idle cycles or on purpose in the same cycle as a tick, which exercises the priority rules.

// File: rtl/pec_pkg.sv
package pec_pkg;

  // Per-cycle actions the control asks of the datapath
  typedef struct packed {
    logic preLoad;    // take write data into the reload register
    logic downLoad;   // take write data into the down-counter
    logic downDec;    // step the down-counter by -1
    logic downReload; // copy the reload register into the down-counter
    logic cntLoad;    // take write data into the event counter
    logic cntInc;     // step the event counter by +1
  } pec_strobes_t;

  // Minimum clock cycles between ticks for a given clock/tick frequency pair
  function automatic int unsigned tickGap(input longint unsigned clkHz,
                                          input longint unsigned tickHz);
    if (tickHz == 0 || clkHz <= tickHz) return 1;
    return int'(clkHz / tickHz);
  endfunction

endpackage

// File: rtl/pec_ctrl.sv
module pec_ctrl
  import pec_pkg::*;
#(
  parameter int unsigned MIN_GAP = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wrPrescale,
  input  logic         wrDown,
  input  logic         wrCount,
  input  logic         downZero,
  output pec_strobes_t strobes
);

  logic tickLive;
  logic downTick;
  logic cntTick;

  // A tick only moves a register that software is not writing this cycle
  assign tickLive = tick;
  assign downTick = tickLive & ~wrDown;
  assign cntTick  = tickLive & ~wrCount;

  always_comb begin
    strobes            = '0;
    strobes.preLoad    = wrPrescale;
    strobes.downLoad   = wrDown;
    strobes.downDec    = downTick & ~downZero;
    strobes.downReload = downTick &  downZero;
    strobes.cntLoad    = wrCount;
    strobes.cntInc     = cntTick & downZero;
  end

  // Input-spacing guard: ticks must be at least MIN_GAP cycles apart
  generate
    if (MIN_GAP > 1) begin : g_gap
      localparam int GW = $clog2(MIN_GAP + 1);
      localparam logic [GW-1:0] GAP_MAX = GW'(MIN_GAP);
      localparam logic [GW-1:0] GAP_LIM = GW'(MIN_GAP - 1);
      logic [GW-1:0] gapCnt;

      always_ff @(posedge clk) begin
        if (!rst_n)              gapCnt <= GAP_MAX;
        else if (tick)           gapCnt <= '0;
        else if (gapCnt < GAP_MAX) gapCnt <= gapCnt + 1'b1;
      end

      // precondition for the counting rules of R2
      assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gapCnt >= GAP_LIM))
        else $error("tick arrived closer than the minimum spacing");
    end
  endgenerate

endmodule

// File: rtl/pec_datapath.sv
module pec_datapath
  import pec_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pec_strobes_t     strobes,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] prescaleReg,
  output logic [WIDTH-1:0] downReg,
  output logic [WIDTH-1:0] countReg,
  output logic             downZero
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] downNext;
  logic [WIDTH-1:0] countNext;
  logic [WIDTH-1:0] prescaleNext;

  assign downZero = (downReg == '0);

  always_comb begin
    prescaleNext = prescaleReg;
    if (strobes.preLoad) prescaleNext = wrData;
  end

  always_comb begin
    downNext = downReg;
    if (strobes.downLoad)        downNext = wrData;
    else if (strobes.downReload) downNext = prescaleReg;  // value before any same-cycle write
    else if (strobes.downDec)    downNext = downReg - ONE;
  end

  always_comb begin
    countNext = countReg;
    if (strobes.cntLoad)     countNext = wrData;
    else if (strobes.cntInc) countNext = countReg + ONE;  // wraps modulo 2^WIDTH
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prescaleReg <= '0;
      downReg     <= '0;
      countReg    <= '0;
    end else begin
      prescaleReg <= prescaleNext;
      downReg     <= downNext;
      countReg    <= countNext;
    end
  end

  // Down-counter actions are mutually exclusive (R7 priority)
  assert_down_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.downLoad, strobes.downReload, strobes.downDec}))
    else $error("conflicting down-counter actions");

  assert_cnt_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobes.cntLoad && strobes.cntInc))
    else $error("conflicting event-counter actions");

endmodule

// File: rtl/prescaled_event_counter.sv
module prescaled_event_counter
  import pec_pkg::*;
#(
  parameter int unsigned     WIDTH   = 32,
  parameter longint unsigned CLK_HZ  = 250_000_000,
  parameter longint unsigned TICK_HZ = 20_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wrPrescale,
  input  logic             wrDown,
  input  logic             wrCount,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] prescaleVal,
  output logic [WIDTH-1:0] downVal,
  output logic [WIDTH-1:0] countVal
);

  localparam int unsigned MIN_GAP = tickGap(CLK_HZ, TICK_HZ);

  pec_strobes_t strobes;
  logic         downZero;

  pec_ctrl #(.MIN_GAP(MIN_GAP)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .wrPrescale (wrPrescale),
    .wrDown     (wrDown),
    .wrCount    (wrCount),
    .downZero   (downZero),
    .strobes    (strobes)
  );

  pec_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .wrData      (wrData),
    .prescaleReg (prescaleVal),
    .downReg     (downVal),
    .countReg    (countVal),
    .downZero    (downZero)
  );

  // Behaviour at the ports
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (prescaleVal == '0 && downVal == '0 && countVal == '0))
    else $error("registers not cleared by reset");

  assert_down_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrDown && downVal != '0) |=> downVal == $past(downVal) - WIDTH'(1))
    else $error("down-counter did not step");

  assert_no_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrCount && downVal != '0) |=> $stable(countVal))
    else $error("event counter moved before reload");

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrDown && downVal == '0) |=> downVal == $past(prescaleVal))
    else $error("reload value not taken");

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrCount && downVal == '0) |=> countVal == $past(countVal) + WIDTH'(1))
    else $error("event counter did not advance on reload");

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wrPrescale && !wrDown && !wrCount) |=>
      ($stable(prescaleVal) && $stable(downVal) && $stable(countVal)))
    else $error("state moved without tick or write");

  assert_write_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrDown |=> downVal == $past(wrData))
    else $error("down-counter write lost");

  assert_write_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrCount |=> countVal == $past(wrData))
    else $error("event counter write lost");

  assert_write_pre_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrPrescale |=> prescaleVal == $past(wrData))
    else $error("reload write lost");

  assert_pre_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wrPrescale |=> $stable(prescaleVal))
    else $error("reload value changed without a write");

endmodule

// File: tb/prescaled_event_counter_bench.sv
module prescaled_event_counter_bench;

  localparam int GAP = 13;  // idle cycles after each tick, above the 12-cycle minimum

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wrPrescale = 1'b0;
  logic        wrDown = 1'b0;
  logic        wrCount = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] prescaleVal, downVal, countVal;

  int vecs = 0;
  int errs = 0;

  always #2 clk = ~clk;  // 250 MHz

  prescaled_event_counter u_prescaled_event_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wrPrescale(wrPrescale),
    .wrDown(wrDown), .wrCount(wrCount), .wrData(wrData),
    .prescaleVal(prescaleVal), .downVal(downVal), .countVal(countVal)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One cycle of stimulus, starting and ending on a falling edge
  task automatic cyc(input logic t, input logic wp, input logic wd,
                     input logic wc, input logic [31:0] d);
    tick = t; wrPrescale = wp; wrDown = wd; wrCount = wc; wrData = d;
    @(negedge clk);
    tick = 1'b0; wrPrescale = 1'b0; wrDown = 1'b0; wrCount = 1'b0; wrData = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setAll(input logic [31:0] p, input logic [31:0] dn,
                        input logic [31:0] c);
    cyc(0, 1, 0, 0, p);
    cyc(0, 0, 1, 0, dn);
    cyc(0, 0, 0, 1, c);
  endtask

  task automatic testReset();
    idle(3);
    chk("R1", "prescale in reset", prescaleVal, 32'd0);
    chk("R1", "down in reset", downVal, 32'd0);
    chk("R1", "count in reset", countVal, 32'd0);
    rst_n = 1'b1;
    idle(1);
    chk("R1", "count after reset", countVal, 32'd0);
    chk("R1", "down after reset", downVal, 32'd0);
  endtask

  task automatic testZeroReload();  // R4
    for (int i = 1; i <= 3; i++) begin
      cyc(1, 0, 0, 0, '0);
      chk("R4", "down stays zero", downVal, 32'd0);
      chk("R4", "count per tick", countVal, 32'(i));
      idle(GAP);
    end
  endtask

  task automatic testWrites();  // R6
    cyc(0, 1, 0, 0, 32'd5);
    chk("R6", "prescale write", prescaleVal, 32'd5);
    cyc(0, 0, 1, 0, 32'd7);
    chk("R6", "down write", downVal, 32'd7);
    cyc(0, 0, 0, 1, 32'd0);
    chk("R6", "count write", countVal, 32'd0);
  endtask

  task automatic testSequence();  // R10, R2, R3
    logic [31:0] seq [14] = '{6, 5, 4, 3, 2, 1, 0, 5, 4, 3, 2, 1, 0, 5};
    for (int i = 0; i < 14; i++) begin
      cyc(1, 0, 0, 0, '0);
      chk("R10", $sformatf("down after tick %0d", i + 1), downVal, seq[i]);
      chk((i == 7 || i == 13) ? "R3" : "R2",
          $sformatf("count after tick %0d", i + 1), countVal,
          (i >= 13) ? 32'd2 : (i >= 7) ? 32'd1 : 32'd0);
      idle(GAP);
    end
  endtask

  task automatic testIdle();  // R5
    setAll(32'd3, 32'd2, 32'd44);
    idle(20);
    chk("R5", "prescale idle", prescaleVal, 32'd3);
    chk("R5", "down idle", downVal, 32'd2);
    chk("R5", "count idle", countVal, 32'd44);
  endtask

  task automatic testPrescaleWrite();  // R8
    setAll(32'd4, 32'd3, 32'd0);
    cyc(0, 1, 0, 0, 32'd9);
    chk("R8", "down untouched by reload write", downVal, 32'd3);
    for (int i = 2; i >= 0; i--) begin
      cyc(1, 0, 0, 0, '0);
      chk("R8", "in-flight count", downVal, 32'(i));
      idle(GAP);
    end
    cyc(1, 0, 0, 0, '0);
    chk("R8", "new reload used", downVal, 32'd9);
    chk("R3", "count on reload", countVal, 32'd1);
    idle(GAP);
    setAll(32'd4, 32'd0, 32'd0);
    cyc(1, 1, 0, 0, 32'd2);
    chk("R8", "same-cycle reload uses old", downVal, 32'd4);
    chk("R8", "reload register updated", prescaleVal, 32'd2);
    idle(GAP);
  endtask

  task automatic testPriority();  // R7
    setAll(32'd6, 32'd0, 32'd10);
    cyc(1, 0, 1, 0, 32'd20);
    chk("R7", "down write beats reload", downVal, 32'd20);
    chk("R7", "count still advances", countVal, 32'd11);
    idle(GAP);
    setAll(32'd6, 32'd5, 32'd10);
    cyc(1, 0, 0, 1, 32'd100);
    chk("R7", "count write beats tick", countVal, 32'd100);
    chk("R7", "down still steps", downVal, 32'd4);
    idle(GAP);
    setAll(32'd6, 32'd0, 32'd10);
    cyc(1, 0, 0, 1, 32'd77);
    chk("R7", "count write beats increment", countVal, 32'd77);
    chk("R7", "down still reloads", downVal, 32'd6);
    idle(GAP);
  endtask

  task automatic testWrap();  // R9
    setAll(32'd0, 32'd0, 32'hFFFF_FFFF);
    cyc(1, 0, 0, 0, '0);
    chk("R9", "count wraps to zero", countVal, 32'd0);
    idle(GAP);
    cyc(1, 0, 0, 0, '0);
    chk("R9", "count after wrap", countVal, 32'd1);
    idle(GAP);
  endtask

  initial begin
    testReset();
    testZeroReload();
    testWrites();
    testSequence();
    testIdle();
    testPrescaleWrite();
    testPriority();
    testWrap();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #800000;
    errs++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule